// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Unit

This unit decides on which clock a simple sequential processor takes its general-purpose maskable interrupt. The request pin is looked at only inside a sampling window. The window is open on the clock before the last clock of each instruction, and on every clock while the core sits in its hold or halt state. Outside the window the request pin is not looked at. A request is taken when it is seen inside the window while the software enable is set.

On taking a request the unit does three things:
- It pulses `accept` for one clock.
- It raises `pc_inhibit`, which stops the program counter from advancing. The line stays high until the bus sequencer reports, through `ack_done`, that the acknowledge cycle has ended. During that cycle an outside agent supplies a restart or call opcode.
- It clears the enable, so nested acceptance cannot happen until software enables interrupts again.

Enable and disable pulses come from the instruction decoder. Reset clears everything. The unit moves no data stream, so every pin is plain level or pulse control with no valid/ready handshake and no back-pressure.

Top module: `intr_accept_unit`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `int_enabled`, `accept` and `pc_inhibit` are all 0.
- R2: A high `sw_en` on a clock edge sets `int_enabled` from the next cycle. A high `sw_dis` clears it. When both are high on the same edge, the disable wins and `int_enabled` reads 0.
- R3: A request (`irq_req`=1) seen with `last_minus1`=1 while `int_enabled`=1 and `pc_inhibit`=0 makes `accept` 1 in the next cycle, for exactly one cycle.
- R4: A request seen while `last_minus1`, `hold_st` and `halt_st` are all 0 produces no `accept` and leaves `int_enabled` unchanged.
- R5: A request seen with `halt_st`=1 or `hold_st`=1 is accepted under the same conditions as R3, even when `last_minus1`=0.
- R6: A request seen while `int_enabled`=0 is ignored and not stored. Enabling later gives an `accept` only if the request is present again at a later sampling point.
- R7: Acceptance clears `int_enabled` on the same edge that raises `accept`. This holds even when `sw_en` is high on that edge.
- R8: `pc_inhibit` rises together with `accept`. It stays 1 until the cycle after `ack_done` is seen high, and then reads 0. `ack_done` has no effect while `pc_inhibit` is 0.
- R9: While `pc_inhibit`=1, no further `accept` occurs, even if the request is held and software has enabled interrupts again (back-to-back requests).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Raw maskable interrupt request |
| last_minus1 | input | 1 | Current clock is the next-to-last clock of the instruction |
| hold_st | input | 1 | Core is in the bus-hold state |
| halt_st | input | 1 | Core is in the halt state |
| sw_en | input | 1 | One-clock enable pulse from the decoder |
| sw_dis | input | 1 | One-clock disable pulse from the decoder |
| ack_done | input | 1 | Acknowledge bus cycle has completed |
| accept | output | 1 | One-clock pulse: request taken |
| pc_inhibit | output | 1 | Blocks program-counter increment |
| int_enabled | output | 1 | Current interrupt enable state |

## Verification
All three results come from one register each. Any stimulus presented before a rising edge shows up on `accept`, `pc_inhibit` and `int_enabled` in the cycle that follows that edge. There is no further latency, including the clearing of `pc_inhibit` after `ack_done`. The bench changes inputs on falling edges and reads the outputs on the next falling edge, so every vector is checked exactly one edge after it was applied. Checking `accept` again on the following vector shows that the pulse lasts one cycle.

// File: rtl/intr_accept_pkg.sv
package intr_accept_pkg;

  // Enable-state update selected by the decoder pulses and acceptance.
  typedef enum logic [1:0] {
    EN_HOLD  = 2'd0,
    EN_SET   = 2'd1,
    EN_CLEAR = 2'd2
  } en_action_e;

  // Sampling window sources, one bit each.
  localparam int unsigned WIN_SRCS = 3;
  localparam int unsigned WIN_LM1  = 0;
  localparam int unsigned WIN_HOLD = 1;
  localparam int unsigned WIN_HALT = 2;

endpackage

// File: rtl/intr_window.sv
module intr_window
  import intr_accept_pkg::*;
#(
  parameter int unsigned N_SRC = WIN_SRCS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] win_src,
  input  logic             irq_req,
  input  logic             en_q,
  input  logic             busy_q,
  output logic             win_open,
  output logic             take
);

  logic [N_SRC-1:0] src_hit;

  // One gate per window source; the window is open if any is set.
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_hit[g] = win_src[g];
  end

  assign win_open = |src_hit;
  assign take     = win_open & irq_req & en_q & ~busy_q;

  // R9
  busy_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !take);

endmodule

// File: rtl/intr_enable_ctrl.sv
module intr_enable_ctrl
  import intr_accept_pkg::*;
#(
  parameter bit DISABLE_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic sw_dis,
  input  logic take,
  output logic en_q
);

  en_action_e act;

  // Acceptance always clears; the generate picks which pulse wins a tie.
  if (DISABLE_WINS) begin : g_dis_first
    always_comb begin
      if (take)        act = EN_CLEAR;
      else if (sw_dis) act = EN_CLEAR;
      else if (sw_en)  act = EN_SET;
      else             act = EN_HOLD;
    end
  end else begin : g_en_first
    always_comb begin
      if (take)        act = EN_CLEAR;
      else if (sw_en)  act = EN_SET;
      else if (sw_dis) act = EN_CLEAR;
      else             act = EN_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else begin
      case (act)
        EN_SET:   en_q <= 1'b1;
        EN_CLEAR: en_q <= 1'b0;
        default:  en_q <= en_q;
      endcase
    end
  end

  // R7
  take_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !en_q);

  // R2
  en_pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !sw_dis && !take) |=> en_q);

  // R2
  dis_pulse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_dis && DISABLE_WINS) |=> !en_q);

endmodule

// File: rtl/intr_ack_tracker.sv
module intr_ack_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic ack_done,
  output logic accept_q,
  output logic inhibit_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_q  <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      accept_q <= take;
      if (take)                       inhibit_q <= 1'b1;
      else if (inhibit_q && ack_done) inhibit_q <= 1'b0;
    end
  end

  // R3
  accept_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |=> !accept_q);

  // R8
  accept_with_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |-> inhibit_q);

  // R8
  inhibit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && !ack_done) |=> inhibit_q);

  // R8
  inhibit_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && ack_done) |=> !inhibit_q);

endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_accept_pkg::*;
#(
  parameter bit DISABLE_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic last_minus1,
  input  logic hold_st,
  input  logic halt_st,
  input  logic sw_en,
  input  logic sw_dis,
  input  logic ack_done,
  output logic accept,
  output logic pc_inhibit,
  output logic int_enabled
);

  logic [WIN_SRCS-1:0] win_src;
  logic                win_open;
  logic                take;
  logic                en_q;
  logic                acc_q;
  logic                inh_q;

  always_comb begin
    win_src           = '0;
    win_src[WIN_LM1]  = last_minus1;
    win_src[WIN_HOLD] = hold_st;
    win_src[WIN_HALT] = halt_st;
  end

  intr_window #(.N_SRC(WIN_SRCS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_src  (win_src),
    .irq_req  (irq_req),
    .en_q     (en_q),
    .busy_q   (inh_q),
    .win_open (win_open),
    .take     (take)
  );

  intr_enable_ctrl #(.DISABLE_WINS(DISABLE_WINS)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_en  (sw_en),
    .sw_dis (sw_dis),
    .take   (take),
    .en_q   (en_q)
  );

  intr_ack_tracker u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .ack_done  (ack_done),
    .accept_q  (acc_q),
    .inhibit_q (inh_q)
  );

  assign accept      = acc_q;
  assign pc_inhibit  = inh_q;
  assign int_enabled = en_q;

  // R4
  no_window_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !accept);

  // R6
  disabled_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enabled |=> !accept);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!accept && !pc_inhibit && !int_enabled));

endmodule

// File: tb/tb_intr_accept_unit.sv
`timescale 1ns/1ps
module tb_intr_accept_unit;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_req, last_minus1, hold_st, halt_st, sw_en, sw_dis, ack_done;
  logic accept, pc_inhibit, int_enabled;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  intr_accept_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .last_minus1(last_minus1),
    .hold_st(hold_st), .halt_st(halt_st), .sw_en(sw_en), .sw_dis(sw_dis),
    .ack_done(ack_done), .accept(accept), .pc_inhibit(pc_inhibit),
    .int_enabled(int_enabled)
  );

  // Vector bits: [9]req [8]lm1 [7]hold [6]halt [5]sw_en [4]sw_dis [3]ack
  //              [2]exp accept [1]exp inhibit [0]exp enabled
  localparam int NV = 22;
  localparam logic [9:0] VEC [NV] = '{
    10'b11_0000_0_000, // 0  R6 disabled request ignored
    10'b00_0010_0_001, // 1  R2 enable
    10'b10_0000_0_001, // 2  R4 no window
    10'b01_0000_0_001, // 3  R6 window, no request
    10'b11_0000_0_110, // 4  R3 accepted, R7 enable cleared
    10'b11_0000_0_010, // 5  R3 pulse ends, R9 held request
    10'b11_0010_0_011, // 6  R9 re-enable while inhibited
    10'b11_0000_0_011, // 7  R9 still blocked by inhibit
    10'b00_0000_1_001, // 8  R8 ack releases inhibit
    10'b00_0000_0_001, // 9  R8 stays released
    10'b10_0100_0_110, // 10 R5 accept during halt
    10'b00_0000_1_000, // 11 R8 release
    10'b00_0000_1_000, // 12 R8 ack with inhibit low ignored
    10'b00_0010_0_001, // 13 R2 enable
    10'b10_1010_0_110, // 14 R5 hold accept, R7 beats sw_en
    10'b00_0000_1_000, // 15 R8 release
    10'b00_0011_0_000, // 16 R2 disable wins tie
    10'b00_0010_0_001, // 17 R2 enable
    10'b00_0001_0_000, // 18 R2 disable
    10'b11_0000_0_000, // 19 R6 disabled request
    10'b00_0010_0_001, // 20 R6 enable after request gone
    10'b01_0000_0_001  // 21 R6 nothing remembered
  };
  localparam int RQ [NV] = '{6,2,4,6,3,3,9,9,8,8,5,8,8,2,7,8,2,2,2,6,6,6};

  task automatic idle_inputs();
    irq_req = 0; last_minus1 = 0; hold_st = 0; halt_st = 0;
    sw_en = 0; sw_dis = 0; ack_done = 0;
  endtask

  task automatic check(input int rq, input logic [2:0] got, input logic [2:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: {accept,pc_inhibit,int_enabled} actual %b expected %b", rq, got, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {accept, pc_inhibit, int_enabled}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {accept, pc_inhibit, int_enabled}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      {irq_req, last_minus1, hold_st, halt_st, sw_en, sw_dis, ack_done} = VEC[i][9:3];
      @(negedge clk);
      check(RQ[i], {accept, pc_inhibit, int_enabled}, VEC[i][2:0]);
    end

    // R1 reset in the middle of an acknowledge sequence
    idle_inputs(); sw_en = 1;
    @(negedge clk);
    sw_en = 0; irq_req = 1; halt_st = 1;
    @(negedge clk);
    check(5, {accept, pc_inhibit, int_enabled}, 3'b110);
    idle_inputs(); sw_en = 1; rst_n = 1'b0;
    @(negedge clk);
    check(1, {accept, pc_inhibit, int_enabled}, 3'b000);
    rst_n = 1'b1; idle_inputs();
    @(negedge clk);
    check(1, {accept, pc_inhibit, int_enabled}, 3'b000);

    // R4 request in no window across several cycles while enabled
    sw_en = 1;
    @(negedge clk);
    sw_en = 0; irq_req = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(4, {accept, pc_inhibit, int_enabled}, 3'b001);
    end
    // R3 window opens with request held
    last_minus1 = 1;
    @(negedge clk);
    check(3, {accept, pc_inhibit, int_enabled}, 3'b110);
    idle_inputs();
    @(negedge clk);
    check(3, {accept, pc_inhibit, int_enabled}, 3'b010);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule